// File: doc/BRIEF.md
# TLB-Backed Linear Page Table Walker

This block turns 32-bit virtual addresses into physical addresses for a memory system built on 4 KB pages and one flat, single-level page table. Each request is first compared against a small fully associative translation cache. A hit answers in the next cycle and makes no memory access. A miss starts a hardware walk. The walk forms the address of the 4-byte table entry from a base register and the page number, reads that entry over a simple memory port and sorts the outcome into one of three results: a good translation, a page fault (the page is mapped but not resident) or an illegal access (the page is unmapped, or a store targets a read-only page).

A good walk keeps the accessed bit, and on stores the dirty bit, of the entry in memory up to date. It writes the entry back only when one of those bits changes, and then installs the mapping in the cache. Faulting walks leave the cache untouched. A flush input, used on context switches or page table edits, discards every cached mapping in a single cycle. Any walk that overlaps a flush is kept out of the cache.

Top module: `addr_xlate_unit`

## Requirements
- R1: The page number is vaddr[31:12] and the page offset is vaddr[11:0]. A miss reads exactly one word at address pt_base + page number * 4.
- R2: Table entry layout: frame number in bits 31:12, valid in bit 0, present in bit 1, writable in bit 2, accessed in bit 3, dirty in bit 4. A good translation returns resp_kind 2'b00 and resp_paddr = {frame number, offset}.
- R3: If the entry has valid = 0, or a store meets writable = 0 (whether that bit comes from memory or from a cached mapping), the result is resp_kind 2'b10 (illegal) and the entry is not written.
- R4: If the entry is valid but has present = 0, the result is resp_kind 2'b01 (page fault) and the entry is not written. The valid check comes first, then present, then write permission.
- R5: A good walk writes the entry back with accessed set, and also with dirty set for a store. The write happens only if this changes the entry, so an entry whose needed bits are already set costs a single read.
- R6: On a cache hit, resp_valid rises in the cycle after the request is accepted, and no memory access takes place.
- R7: A store that hits a cached mapping whose dirty bit is clear is handled as a miss. It walks, writes dirty back, refreshes the cached copy, and a later store to that page then hits.
- R8: A walk that ends in a page fault or an illegal access never installs a mapping, so repeating the access walks again.
- R9: A one-cycle flush pulse discards all cached mappings, and the next access to any page walks.
- R10: A flush during any cycle of a walk, including the cycle in which the walk completes, stops that walk from installing its mapping. A request accepted in the same cycle as a flush is handled as a miss, and its walk does install its mapping.
- R11: The cache holds 8 mappings and replaces them in round-robin order. Refreshing a page that is already cached reuses that page's slot and does not advance the replacement pointer.
- R12: mem_req stays high with mem_addr, mem_we and mem_wdata stable until mem_ack. Each acknowledged cycle completes one transfer. req_ready is high only when no translation is in progress, and resp_valid lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all cached mappings |
| pt_base | input | 32 | Physical address of the page table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Unit idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_store | input | 1 | 1 = store access, 0 = load access |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_kind | output | 2 | 00 translated, 01 page fault, 10 illegal |
| resp_paddr | output | 32 | Physical address (zero on faults) |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write entry, 0 = read entry |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Entry written back |
| mem_ack | input | 1 | Transfer done this cycle |
| mem_rdata | input | 32 | Entry read, valid with mem_ack |

## Verification
The flush input can land in the same cycle as another cache function: a lookup of a new request, a walk still in flight, or the completing cycle of a walk that would install a mapping. The bench provokes all three. It raises flush together with a request that would otherwise hit, raises it for one cycle while the memory model is still holding back the read, and has the memory model raise it in the same cycle as its acknowledge. Each case is judged by the number of memory reads that the next access to the same page causes: one read shows the mapping was kept out, zero reads shows it was installed.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    localparam int ADDR_W = 32;
    localparam int PAGE_W = 12;
    localparam int VPN_W  = ADDR_W - PAGE_W;
    localparam int PTE_SH = 2;   // entries are 4 bytes wide

    localparam int BIT_V = 0;
    localparam int BIT_P = 1;
    localparam int BIT_W = 2;
    localparam int BIT_A = 3;
    localparam int BIT_D = 4;

    typedef enum logic [1:0] {
        XL_OK      = 2'b00,
        XL_PFAULT  = 2'b01,
        XL_ILLEGAL = 2'b10
    } xl_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_RESP
    } walk_st_e;

    typedef struct packed {
        logic [VPN_W-1:0] pfn;
        logic             wr;
        logic             dirty;
    } tlb_data_t;

    function automatic xl_kind_e pte_classify(input logic [ADDR_W-1:0] pte, input logic store);
        if (!pte[BIT_V])               return XL_ILLEGAL;
        else if (!pte[BIT_P])          return XL_PFAULT;
        else if (store && !pte[BIT_W]) return XL_ILLEGAL;
        else                           return XL_OK;
    endfunction

    function automatic logic [ADDR_W-1:0] pte_touch(input logic [ADDR_W-1:0] pte, input logic store);
        logic [ADDR_W-1:0] r;
        r = pte;
        r[BIT_A] = 1'b1;
        if (store) r[BIT_D] = 1'b1;
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] pte_addr(input logic [ADDR_W-1:0] base, input logic [VPN_W-1:0] vpn);
        return base + ADDR_W'({vpn, {PTE_SH{1'b0}}});
    endfunction

endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb
    import xlate_pkg::*;
#(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output tlb_data_t        lk_data,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  tlb_data_t        fill_data
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     vld;
    logic [VPN_W-1:0] tag [N];
    tlb_data_t        dat [N];
    logic [IDX_W-1:0] rr;

    logic [N-1:0]     lk_match;
    logic [N-1:0]     fill_match;
    logic [IDX_W-1:0] fill_slot;
    logic             fill_reuse;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign lk_match[i]   = vld[i] && (tag[i] == lk_vpn);
        assign fill_match[i] = vld[i] && (tag[i] == fill_vpn);
    end

    always_comb begin
        lk_hit  = |lk_match;
        lk_data = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_match[i]) lk_data = dat[i];
        end
    end

    always_comb begin
        fill_reuse = |fill_match;
        fill_slot  = rr;
        for (int i = 0; i < N; i++) begin
            if (fill_match[i]) fill_slot = IDX_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            rr  <= '0;
        end else if (flush) begin
            vld <= '0;
        end else if (fill_en) begin
            vld[fill_slot] <= 1'b1;
            if (!fill_reuse) begin
                rr <= (rr == IDX_W'(N - 1)) ? '0 : rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            tag[fill_slot] <= fill_vpn;
            dat[fill_slot] <= fill_data;
        end
    end

    // R11: a page never occupies two slots
    assert_single_slot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

    // R9: every mapping is gone one cycle after a flush
    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (vld == '0));

    // R11: refreshing a held page leaves the replacement pointer alone
    assert_reuse_keeps_ptr_R11: assert property (@(posedge clk) disable iff (rst)
        (fill_en && fill_reuse && !flush) |=> $stable(rr));

endmodule

// File: rtl/xlate_walk.sv
module xlate_walk
    import xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [ADDR_W-1:0] pt_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_store,
    output logic [VPN_W-1:0]  lk_vpn,
    input  logic              tlb_hit,
    input  tlb_data_t         tlb_data,
    output logic              fill_en,
    output logic [VPN_W-1:0]  fill_vpn,
    output tlb_data_t         fill_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              resp_valid,
    output xl_kind_e          resp_kind,
    output logic [ADDR_W-1:0] resp_paddr
);
    walk_st_e          st;
    logic [VPN_W-1:0]  vpn_q;
    logic [PAGE_W-1:0] off_q;
    logic              store_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] pte_q;
    logic              nofill_q;
    xl_kind_e          kind_q;
    logic [ADDR_W-1:0] pa_q;

    logic              hit_use, hit_ill, hit_fast;
    xl_kind_e          rd_kind;
    logic [ADDR_W-1:0] rd_new;
    logic              rd_clean;
    logic [ADDR_W-1:0] fill_src;

    assign lk_vpn   = req_vaddr[ADDR_W-1:PAGE_W];
    assign hit_use  = tlb_hit && !flush;
    assign hit_ill  = hit_use && req_store && !tlb_data.wr;
    assign hit_fast = hit_use && (!req_store || (tlb_data.wr && tlb_data.dirty));

    assign rd_kind  = pte_classify(mem_rdata, store_q);
    assign rd_new   = pte_touch(mem_rdata, store_q);
    assign rd_clean = (rd_new == mem_rdata);

    assign req_ready  = (st == S_IDLE);
    assign resp_valid = (st == S_RESP);
    assign resp_kind  = kind_q;
    assign resp_paddr = pa_q;

    assign mem_req   = (st == S_READ) || (st == S_WRITE);
    assign mem_we    = (st == S_WRITE);
    assign mem_addr  = pte_addr(base_q, vpn_q);
    assign mem_wdata = pte_q;

    always_comb begin
        fill_src = (st == S_WRITE) ? pte_q : rd_new;
        fill_en  = !flush && !nofill_q && mem_ack &&
                   ((st == S_WRITE) || ((st == S_READ) && (rd_kind == XL_OK) && rd_clean));
        fill_vpn = vpn_q;
        fill_data.pfn   = fill_src[ADDR_W-1:PAGE_W];
        fill_data.wr    = fill_src[BIT_W];
        fill_data.dirty = fill_src[BIT_D];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            nofill_q <= 1'b0;
            kind_q   <= XL_OK;
            pa_q     <= '0;
            vpn_q    <= '0;
            off_q    <= '0;
            store_q  <= 1'b0;
            base_q   <= '0;
            pte_q    <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        vpn_q    <= lk_vpn;
                        off_q    <= req_vaddr[PAGE_W-1:0];
                        store_q  <= req_store;
                        base_q   <= pt_base;
                        nofill_q <= 1'b0;
                        if (hit_ill) begin
                            kind_q <= XL_ILLEGAL;
                            pa_q   <= '0;
                            st     <= S_RESP;
                        end else if (hit_fast) begin
                            kind_q <= XL_OK;
                            pa_q   <= {tlb_data.pfn, req_vaddr[PAGE_W-1:0]};
                            st     <= S_RESP;
                        end else begin
                            st <= S_READ;
                        end
                    end
                end
                S_READ: begin
                    if (flush) nofill_q <= 1'b1;
                    if (mem_ack) begin
                        pte_q <= rd_new;
                        if (rd_kind != XL_OK) begin
                            kind_q <= rd_kind;
                            pa_q   <= '0;
                            st     <= S_RESP;
                        end else if (!rd_clean) begin
                            st <= S_WRITE;
                        end else begin
                            kind_q <= XL_OK;
                            pa_q   <= {mem_rdata[ADDR_W-1:PAGE_W], off_q};
                            st     <= S_RESP;
                        end
                    end
                end
                S_WRITE: begin
                    if (flush) nofill_q <= 1'b1;
                    if (mem_ack) begin
                        kind_q <= XL_OK;
                        pa_q   <= {pte_q[ADDR_W-1:PAGE_W], off_q};
                        st     <= S_RESP;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R12: an unanswered transfer keeps its request, address and direction
    assert_hold_request_R12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R5: every write-back carries a resident, valid, accessed entry
    assert_writeback_accessed_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wdata[BIT_A] && mem_wdata[BIT_V] && mem_wdata[BIT_P]));

    // R5: write-back for a store carries the dirty bit
    assert_writeback_dirty_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && store_q) |-> mem_wdata[BIT_D]);

    // R8: an installed mapping always goes with a good result
    assert_fill_only_on_ok_R8: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (resp_valid && (resp_kind == XL_OK)));

    // R12: result strobe is a single cycle and the unit is idle after it
    assert_resp_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> (!resp_valid && req_ready));

endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
    import xlate_pkg::*;
#(
    parameter int TLB_N = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic [31:0] pt_base,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic        req_store,
    output logic        resp_valid,
    output logic [1:0]  resp_kind,
    output logic [31:0] resp_paddr,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    logic [VPN_W-1:0] lk_vpn;
    logic             tlb_hit;
    tlb_data_t        tlb_data;
    logic             fill_en;
    logic [VPN_W-1:0] fill_vpn;
    tlb_data_t        fill_data;
    xl_kind_e         kind;

    xlate_tlb #(.N(TLB_N)) u_tlb (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .lk_vpn    (lk_vpn),
        .lk_hit    (tlb_hit),
        .lk_data   (tlb_data),
        .fill_en   (fill_en),
        .fill_vpn  (fill_vpn),
        .fill_data (fill_data)
    );

    xlate_walk u_walk (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .pt_base    (pt_base),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .req_store  (req_store),
        .lk_vpn     (lk_vpn),
        .tlb_hit    (tlb_hit),
        .tlb_data   (tlb_data),
        .fill_en    (fill_en),
        .fill_vpn   (fill_vpn),
        .fill_data  (fill_data),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .resp_valid (resp_valid),
        .resp_kind  (kind),
        .resp_paddr (resp_paddr)
    );

    assign resp_kind = kind;

endmodule

// File: tb/test_addr_xlate_unit.sv
`timescale 1ns/1ps
module test_addr_xlate_unit;

    localparam logic [31:0] BASE = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_store = 1'b0;
    logic        resp_valid;
    logic [1:0]  resp_kind;
    logic [31:0] resp_paddr;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic flush_drv = 1'b0;
    logic flush_on_ack = 1'b0;
    logic flush_ack_r = 1'b0;
    assign flush = flush_drv | flush_ack_r;

    always #4 clk = ~clk;

    addr_xlate_unit i_addr_xlate_unit (
        .clk(clk), .rst(rst), .flush(flush), .pt_base(BASE),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_store(req_store),
        .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_paddr(resp_paddr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // ---------------- memory model: page table of 64 entries ----------------
    logic [31:0] wmem [64];
    logic [63:0] written = '0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    int          wait_cnt = 0;
    logic        ack_r = 1'b0;
    logic [31:0] rdata_r = '0;
    logic [31:0] last_addr = '0;

    function automatic logic [31:0] init_pte(input int idx);
        case (idx)
            1: return 32'h00A1_1007;
            2: return 32'h00B2_2003;
            3: return 32'h00C3_3001;
            4: return 32'h00D4_4000;
            5: return 32'h00E5_501F;
            6: return 32'h00F6_6007;
            7: return 32'h00F7_7003;
            8: return 32'h0080_8007;
            default: begin
                if (idx >= 10 && idx <= 31) return {20'h30000 + 20'(idx), 12'h01F};
                return 32'h0;
            end
        endcase
    endfunction

    function automatic logic [31:0] peek(input logic [31:0] a);
        logic [31:0] d;
        int idx;
        d = a - BASE;
        if (d >= 32'd256) return 32'h0;
        idx = int'(d[7:2]);
        return written[idx] ? wmem[idx] : init_pte(idx);
    endfunction

    logic [31:0] m_off;
    logic [5:0]  m_idx;
    assign m_off = mem_addr - BASE;
    assign m_idx = m_off[7:2];

    always @(posedge clk) begin
        flush_ack_r <= 1'b0;
        if (ack_r) begin
            ack_r <= 1'b0;
        end else if (mem_req) begin
            if (wait_cnt == 1) begin
                wait_cnt    <= 0;
                ack_r       <= 1'b1;
                flush_ack_r <= flush_on_ack;
                last_addr   <= mem_addr;
                if (mem_we) begin
                    wr_cnt <= wr_cnt + 1;
                    if (m_off < 32'd256) begin
                        wmem[m_idx]    <= mem_wdata;
                        written[m_idx] <= 1'b1;
                    end
                end else begin
                    rd_cnt  <= rd_cnt + 1;
                    rdata_r <= peek(mem_addr);
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end
    assign mem_ack   = ack_r;
    assign mem_rdata = rdata_r;

    // ---------------- checking ----------------
    int checks = 0;
    int fails  = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [31:0] va;
        logic        st;
        logic [1:0]  kind;
        logic [31:0] pa;
        logic [1:0]  nrd;
        logic [1:0]  nwr;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1123, 1'b0, 2'b00, 32'h00A1_1123, 2'd1, 2'd1},
        '{32'h0000_1456, 1'b0, 2'b00, 32'h00A1_1456, 2'd0, 2'd0},
        '{32'h0000_1010, 1'b1, 2'b00, 32'h00A1_1010, 2'd1, 2'd1},
        '{32'h0000_1FFC, 1'b1, 2'b00, 32'h00A1_1FFC, 2'd0, 2'd0},
        '{32'h0000_2ABC, 1'b0, 2'b00, 32'h00B2_2ABC, 2'd1, 2'd1},
        '{32'h0000_2ABC, 1'b1, 2'b10, 32'h0,         2'd0, 2'd0},
        '{32'h0000_3000, 1'b0, 2'b01, 32'h0,         2'd1, 2'd0},
        '{32'h0000_3004, 1'b0, 2'b01, 32'h0,         2'd1, 2'd0},
        '{32'h0000_4000, 1'b0, 2'b10, 32'h0,         2'd1, 2'd0},
        '{32'h0000_5777, 1'b0, 2'b00, 32'h00E5_5777, 2'd1, 2'd0},
        '{32'h0000_5778, 1'b1, 2'b00, 32'h00E5_5778, 2'd0, 2'd0},
        '{32'h0000_7000, 1'b1, 2'b10, 32'h0,         2'd1, 2'd0},
        '{32'hFFFF_F123, 1'b0, 2'b10, 32'h0,         2'd1, 2'd0}
    };

    // fmode: 0 none, 1 flush with request, 2 flush one cycle into walk, 3 flush with memory ack
    task automatic xlate(input string tag, input logic [31:0] va, input logic st,
                         input logic [1:0] ek, input logic [31:0] epa,
                         input int erd, input int ewr, input int fmode);
        int rd0, wr0, lat;
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        req_store = st;
        if (fmode == 1) flush_drv = 1'b1;
        if (fmode == 3) flush_on_ack = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        flush_drv = 1'b0;
        if (fmode == 2) flush_drv = 1'b1;
        lat = 0;
        while (!resp_valid && lat < 1000) begin
            @(negedge clk);
            flush_drv = 1'b0;
            lat++;
        end
        flush_drv    = 1'b0;
        flush_on_ack = 1'b0;
        check({tag, " result code"}, 32'(resp_kind), 32'(ek));
        if (ek == 2'b00) check({tag, " R2 physical address"}, resp_paddr, epa);
        check({tag, " R1 entry reads"}, 32'(rd_cnt - rd0), 32'(erd));
        check({tag, " R5 entry writes"}, 32'(wr_cnt - wr0), 32'(ewr));
        if (erd == 0) check({tag, " R6 hit latency"}, 32'(lat), 32'd0);
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush_drv = 1'b1;
        @(negedge clk);
        flush_drv = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R12 watchdog: actual hung expected completion");
        summary();
        $finish;
    end

    initial begin
        string tag;
        do_reset();
        // reset state (R12)
        check("R12 reset ready", 32'(req_ready), 32'd1);
        check("R12 reset resp_valid", 32'(resp_valid), 32'd0);
        check("R12 reset mem_req", 32'(mem_req), 32'd0);

        // vector table: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].kind == 2'b01)      tag = $sformatf("R4 vec%0d", i);
            else if (VECS[i].kind == 2'b10) tag = $sformatf("R3 vec%0d", i);
            else if (VECS[i].nrd == 2'd0)   tag = $sformatf("R6 vec%0d", i);
            else if (VECS[i].st)            tag = $sformatf("R7 vec%0d", i);
            else                            tag = $sformatf("R2 vec%0d", i);
            xlate(tag, VECS[i].va, VECS[i].st, VECS[i].kind, VECS[i].pa,
                  int'(VECS[i].nrd), int'(VECS[i].nwr), 0);
        end
        // R1: entry address for the top page number
        check("R1 entry address for page 0xFFFFF", last_addr, 32'h004F_FFFC);
        // R5: entries written back in memory
        check("R5 page 1 entry accessed+dirty", peek(BASE + 32'd4), 32'h00A1_101F);
        check("R5 page 2 entry accessed only", peek(BASE + 32'd8), 32'h00B2_200B);
        check("R8 page 3 entry untouched", peek(BASE + 32'd12), 32'h00C3_3001);
        check("R3 page 7 entry untouched", peek(BASE + 32'd28), 32'h00F7_7003);

        // R9: flush while idle
        xlate("R9 before flush", 32'h0000_1200, 1'b0, 2'b00, 32'h00A1_1200, 0, 0, 0);
        pulse_flush();
        xlate("R9 after flush page 1", 32'h0000_1200, 1'b0, 2'b00, 32'h00A1_1200, 1, 0, 0);
        xlate("R9 after flush page 2", 32'h0000_2000, 1'b0, 2'b00, 32'h00B2_2000, 1, 0, 0);

        // R10: flush together with the request
        xlate("R10 flush with request", 32'h0000_1300, 1'b0, 2'b00, 32'h00A1_1300, 1, 0, 1);
        xlate("R10 walk after flush filled", 32'h0000_1304, 1'b0, 2'b00, 32'h00A1_1304, 0, 0, 0);

        // R10: flush during walk
        xlate("R10 flush mid-walk", 32'h0000_8040, 1'b0, 2'b00, 32'h0080_8040, 1, 1, 2);
        xlate("R10 mid-walk not filled", 32'h0000_8044, 1'b0, 2'b00, 32'h0080_8044, 1, 0, 0);
        check("R5 page 8 entry accessed", peek(BASE + 32'd32), 32'h0080_800F);

        // R10: flush in the completing cycle
        xlate("R10 flush with ack", 32'h0001_4010, 1'b0, 2'b00, 32'h3001_4010, 1, 0, 3);
        xlate("R10 ack-cycle not filled", 32'h0001_4014, 1'b0, 2'b00, 32'h3001_4014, 1, 0, 0);
        xlate("R10 later walk filled", 32'h0001_4018, 1'b0, 2'b00, 32'h3001_4018, 0, 0, 0);

        // R11: round-robin replacement and slot reuse
        do_reset();
        xlate("R11 page 6 load", 32'h0000_6100, 1'b0, 2'b00, 32'h00F6_6100, 1, 1, 0);
        xlate("R7 page 6 clean store", 32'h0000_6104, 1'b1, 2'b00, 32'h00F6_6104, 1, 1, 0);
        check("R7 page 6 entry dirty", peek(BASE + 32'd24), 32'h00F6_601F);
        for (int v = 10; v <= 16; v++) begin
            xlate("R11 fill", {12'h0, 8'(v), 12'h020}, 1'b0, 2'b00,
                  {20'h30000 + 20'(v), 12'h020}, 1, 0, 0);
        end
        xlate("R11 reused slot kept page 6", 32'h0000_6108, 1'b1, 2'b00, 32'h00F6_6108, 0, 0, 0);
        xlate("R11 ninth page", 32'h0001_1000, 1'b0, 2'b00, 32'h3001_1000, 1, 0, 0);
        xlate("R11 page 6 evicted", 32'h0000_610C, 1'b0, 2'b00, 32'h00F6_610C, 1, 0, 0);
        xlate("R11 page 11 still held", 32'h0000_B000, 1'b0, 2'b00, 32'h3000_B000, 0, 0, 0);
        xlate("R11 page 10 replaced", 32'h0000_A000, 1'b0, 2'b00, 32'h3000_A000, 1, 0, 0);

        summary();
        $finish;
    end

endmodule